// File: doc/BRIEF.md
# Chained Multiply-Add Unit

This unit forms the full unsigned product of two 64-bit operands, adds a third 64-bit operand treated as an unsigned value, and delivers the 128-bit sum as two 64-bit halves. The low half is tagged for a primary destination register. The high half is tagged for a second destination register that the instruction never names.

In scalar mode the unit performs one such operation. The second destination is the register directly after the primary one. In vector mode a small sequencer steps through up to `MAX_VL` elements. For each element it requests one operand word through `elemIdx` and multiplies it by a scalar multiplier held for the whole run. It then adds the high half left by the previous element. This forms one row of a big-integer multiply by a single word. Only the initial addend enters from outside, and only the last high half leaves as `carryOut`. Each element's second destination sits `MAX_VL` registers above its primary destination, so that the high halves of successive elements land in distinct registers.

A caller raises `start` for one cycle while `busy` is low. It then supplies `opA` for the index shown on `elemIdx` in each following cycle, and collects one tagged result per cycle until `done` pulses.

Top module: `chain_mac`

## Requirements
- R1: {resHi, resLo} equals the full 128-bit unsigned value opA*multiplier + addend. With all three inputs at all ones, resHi is all ones and resLo is zero, and no bit is lost.
- R2: The addend is zero-extended. An addend with bit 63 set never subtracts from the high half.
- R3: In scalar mode (vecMode=0) exactly one result is produced and vecLen has no effect. Its rtIdx is rtBase and its rsIdx is rtBase+1, both modulo 2^IDX_W.
- R4: In vector mode (vecMode=1), element i carries rtIdx = rtBase+i and rsIdx = rtBase+i+MAX_VL, both modulo 2^IDX_W.
- R5: In vector mode, element 0 adds addendIn, and each later element adds the resHi of the element before it. After the run, carryOut equals the last resHi.
- R6: Let the start edge be E0. Element i is requested on elemIdx in the cycle after E(i), and opA is sampled at E(i+1). Its result is shown with resValid high in the cycle after E(i+1), one element per cycle without gaps.
- R7: done is high for exactly one cycle, the cycle after the last result was shown. busy is low in that cycle, and resValid is low in it.
- R8: start is ignored while busy is high. Neither the running sequence nor its latched multiplier, addend or rtBase changes.
- R9: A vector run with vecLen=0 shows no result. It pulses done in the cycle after E1, with carryOut equal to addendIn.
- R10: In vector mode a vecLen above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| vecMode | input | 1 | 0 = single scalar operation, 1 = chained vector run |
| vecLen | input | CNT_W | Element count for vector mode |
| rtBase | input | IDX_W | Primary destination index of element 0 |
| multiplier | input | DATA_W | Scalar multiplier, latched at start |
| addendIn | input | DATA_W | Initial addend (incoming carry), latched at start |
| elemIdx | output | CNT_W | Index of the element whose operand is wanted now |
| opA | input | DATA_W | Element operand for elemIdx |
| busy | output | 1 | Operation in progress |
| resValid | output | 1 | Result outputs hold a new element |
| rtIdx | output | IDX_W | Destination index for resLo |
| rsIdx | output | IDX_W | Destination index for resHi |
| resLo | output | DATA_W | Low half of the sum |
| resHi | output | DATA_W | High half of the sum |
| carryOut | output | DATA_W | Outgoing carry, the last high half |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting from the edge that accepts start as E0, the result of element i is due just after E(i+1). It passes through one register for the request index and one for the result. done is due one edge after the last result, or just after E1 for an empty run. The bench drives every input at a falling edge and samples at the next falling edge after the edge a result is due on. Its expected high halves are carried forward element by element from its own 128-bit arithmetic. A start pulse injected mid-run is checked by confirming that the remaining results still follow the first run's latched operands and indices.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } seqState_t;

  typedef struct packed {
    logic load;   // capture operands for a new run
    logic step;   // process the element on elemIdx
  } ctrlStrobe_t;
endpackage

// File: rtl/cmac_control.sv
module cmac_control
  import cmac_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             vecMode,
  input  logic [CNT_W-1:0] vecLen,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] elemCount,
  output logic             busy,
  output logic             done
);
  seqState_t        state;
  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] effLen;
  logic             lastStep;

  always_comb begin
    if (!vecMode)
      effLen = CNT_W'(1);
    else if (vecLen > CNT_W'(MAX_VL))
      effLen = CNT_W'(MAX_VL);
    else
      effLen = vecLen;
  end

  assign strobe.load = (state == ST_IDLE) && start;
  assign strobe.step = (state == ST_RUN);
  assign lastStep    = (state == ST_RUN) && (elemCount == lenQ - CNT_W'(1));
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      elemCount <= '0;
      lenQ      <= '0;
      done      <= 1'b0;
    end else begin
      done <= (state == ST_DRAIN);
      unique case (state)
        ST_IDLE: if (start) begin
          elemCount <= '0;
          lenQ      <= effLen;
          state     <= (effLen == '0) ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: begin
          elemCount <= elemCount + CNT_W'(1);
          if (lastStep) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R8: a run keeps going until its last element, whatever start does
  a_r8_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !lastStep) |=> (state == ST_RUN));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a run never holds more elements than the vector capacity
  a_r10_len_clamp: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (lenQ <= CNT_W'(MAX_VL)));

  // R9: an empty run skips straight to completion
  a_r9_empty_run: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && vecMode && vecLen == '0) |=> (state == ST_DRAIN));
endmodule

// File: rtl/cmac_datapath.sv
module cmac_datapath
  import cmac_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 7,
  parameter int MAX_VL     = 8,
  parameter int NUM_SLICES = 2,
  localparam int CNT_W   = $clog2(MAX_VL + 1),
  localparam int PROD_W  = 2 * DATA_W,
  localparam int SLICE_W = DATA_W / NUM_SLICES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  elemCount,
  input  logic              vecMode,
  input  logic [IDX_W-1:0]  rtBase,
  input  logic [DATA_W-1:0] multiplier,
  input  logic [DATA_W-1:0] addendIn,
  input  logic [DATA_W-1:0] opA,
  output logic              resValid,
  output logic [IDX_W-1:0]  rtIdx,
  output logic [IDX_W-1:0]  rsIdx,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic [DATA_W-1:0] carryOut
);
  logic              vecQ;
  logic [IDX_W-1:0]  baseQ;
  logic [DATA_W-1:0] multQ;
  logic [DATA_W-1:0] accQ;

  logic [PROD_W-1:0] partial [NUM_SLICES];
  logic [PROD_W-1:0] sumFull;
  logic [IDX_W-1:0]  rtNext;
  logic [IDX_W-1:0]  rsNext;

  // one partial product per multiplier slice, shifted into place
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    assign partial[k] =
      (PROD_W'(opA) * PROD_W'(multQ[k*SLICE_W +: SLICE_W])) << (k * SLICE_W);
  end

  // addend enters zero-extended; the carried high half is the addend
  always_comb begin
    sumFull = PROD_W'(accQ);
    for (int j = 0; j < NUM_SLICES; j++) sumFull = sumFull + partial[j];
  end

  always_comb begin
    rtNext = baseQ + (vecQ ? IDX_W'(elemCount) : '0);
    rsNext = vecQ ? rtNext + IDX_W'(MAX_VL) : baseQ + IDX_W'(1);
  end

  assign carryOut = accQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ     <= 1'b0;
      baseQ    <= '0;
      multQ    <= '0;
      accQ     <= '0;
      resValid <= 1'b0;
      rtIdx    <= '0;
      rsIdx    <= '0;
      resLo    <= '0;
      resHi    <= '0;
    end else begin
      resValid <= strobe.step;
      if (strobe.load) begin
        vecQ  <= vecMode;
        baseQ <= rtBase;
        multQ <= multiplier;
        accQ  <= addendIn;
      end
      if (strobe.step) begin
        resLo <= sumFull[DATA_W-1:0];
        resHi <= sumFull[PROD_W-1:DATA_W];
        accQ  <= sumFull[PROD_W-1:DATA_W];
        rtIdx <= rtNext;
        rsIdx <= rsNext;
      end
    end
  end

  // R6: each step yields a result on the following cycle
  a_r6_valid_follows_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> resValid);

  // R4: vector high halves land MAX_VL above the low half
  a_r4_rs_offset: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && vecQ) |-> (rsIdx == rtIdx + IDX_W'(MAX_VL)));

  // R3: scalar high half goes to the next register
  a_r3_rs_next: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !vecQ) |-> (rsIdx == rtIdx + IDX_W'(1)));

  // R5: outgoing carry tracks the latest high half
  a_r5_carry_tracks: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (carryOut == resHi));
endmodule

// File: rtl/chain_mac.sv
module chain_mac
  import cmac_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int IDX_W      = 7,
  parameter int MAX_VL     = 8,
  parameter int NUM_SLICES = 2,
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              vecMode,
  input  logic [CNT_W-1:0]  vecLen,
  input  logic [IDX_W-1:0]  rtBase,
  input  logic [DATA_W-1:0] multiplier,
  input  logic [DATA_W-1:0] addendIn,
  output logic [CNT_W-1:0]  elemIdx,
  input  logic [DATA_W-1:0] opA,
  output logic              busy,
  output logic              resValid,
  output logic [IDX_W-1:0]  rtIdx,
  output logic [IDX_W-1:0]  rsIdx,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic [DATA_W-1:0] carryOut,
  output logic              done
);
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] elemCount;

  assign elemIdx = elemCount;

  cmac_control #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .vecMode   (vecMode),
    .vecLen    (vecLen),
    .strobe    (strobe),
    .elemCount (elemCount),
    .busy      (busy),
    .done      (done)
  );

  cmac_datapath #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .MAX_VL     (MAX_VL),
    .NUM_SLICES (NUM_SLICES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .elemCount  (elemCount),
    .vecMode    (vecMode),
    .rtBase     (rtBase),
    .multiplier (multiplier),
    .addendIn   (addendIn),
    .opA        (opA),
    .resValid   (resValid),
    .rtIdx      (rtIdx),
    .rsIdx      (rsIdx),
    .resLo      (resLo),
    .resHi      (resHi),
    .carryOut   (carryOut)
  );
endmodule

// File: tb/tb_chain_mac.sv
module tb_chain_mac;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 7;
  localparam int MAX_VL = 8;
  localparam int CNT_W  = $clog2(MAX_VL + 1);
  localparam int NVEC   = 6;

  // scalar stimulus: {opA, multiplier, addend}
  localparam logic [3*DATA_W-1:0] SCAL [NVEC] = '{
    {64'd3, 64'd5, 64'd7},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'd0, 64'd0, 64'h8000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0},
    {64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hFFFF_0000_FFFF_0000},
    {64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF}
  };
  localparam logic [IDX_W-1:0] SBASE [NVEC] = '{7'd0, 7'd127, 7'd20, 7'd3, 7'd64, 7'd126};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic vecMode = 1'b0;
  logic [CNT_W-1:0] vecLen = '0;
  logic [IDX_W-1:0] rtBase = '0;
  logic [DATA_W-1:0] multiplier = '0;
  logic [DATA_W-1:0] addendIn = '0;
  logic [CNT_W-1:0] elemIdx;
  logic [DATA_W-1:0] opA;
  logic busy, resValid, done;
  logic [IDX_W-1:0] rtIdx, rsIdx;
  logic [DATA_W-1:0] resLo, resHi, carryOut;
  logic [DATA_W-1:0] opMem [MAX_VL];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign opA = (elemIdx < CNT_W'(MAX_VL)) ? opMem[elemIdx[CNT_W-2:0]] : '0;

  chain_mac dut (
    .clk(clk), .rstN(rstN), .start(start), .vecMode(vecMode), .vecLen(vecLen),
    .rtBase(rtBase), .multiplier(multiplier), .addendIn(addendIn),
    .elemIdx(elemIdx), .opA(opA), .busy(busy), .resValid(resValid),
    .rtIdx(rtIdx), .rsIdx(rsIdx), .resLo(resLo), .resHi(resHi),
    .carryOut(carryOut), .done(done)
  );

  function automatic logic [127:0] mulAdd(logic [63:0] a, logic [63:0] b, logic [63:0] c);
    return {64'd0, a} * {64'd0, b} + {64'd0, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one run; vm selects mode, inject pulses start mid-run with other operands
  task automatic runOp(input bit vm, input int vl, input logic [IDX_W-1:0] base,
                       input logic [63:0] b, input logic [63:0] c, input bit inject);
    int eff;
    logic [63:0] carry;
    logic [127:0] exp;
    logic [IDX_W-1:0] expRs;
    eff = vm ? ((vl > MAX_VL) ? MAX_VL : vl) : 1;
    carry = c;
    @(negedge clk);
    start = 1'b1; vecMode = vm; vecLen = CNT_W'(vl);
    rtBase = base; multiplier = b; addendIn = c;
    @(negedge clk);            // E0 has passed
    start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", 128'(busy), 128'd1);
    for (int i = 0; i < eff; i++) begin
      chk(elemIdx == CNT_W'(i), "R6 elemIdx", 128'(elemIdx), 128'(i));
      if (inject && i == 1) begin
        start = 1'b1; vecMode = 1'b0; rtBase = 7'd0;
        multiplier = 64'hDEAD_BEEF; addendIn = 64'd99;
      end
      @(negedge clk);          // E(i+1) has passed
      start = 1'b0;
      exp = mulAdd(opMem[i], b, carry);
      expRs = vm ? IDX_W'(base + IDX_W'(i) + IDX_W'(MAX_VL)) : IDX_W'(base + 1);
      chk(resValid == 1'b1, "R6 resValid", 128'(resValid), 128'd1);
      chk({resHi, resLo} == exp, vm ? "R5 chained sum" : "R1 sum", {resHi, resLo}, exp);
      chk(rtIdx == IDX_W'(base + (vm ? IDX_W'(i) : '0)), vm ? "R4 rtIdx" : "R3 rtIdx",
          128'(rtIdx), 128'(base + (vm ? IDX_W'(i) : '0)));
      chk(rsIdx == expRs, vm ? "R4 rsIdx" : "R3 rsIdx", 128'(rsIdx), 128'(expRs));
      chk(done == 1'b0, "R7 no early done", 128'(done), 128'd0);
      carry = exp[127:64];
    end
    @(negedge clk);            // one edge after the last result
    chk(done == 1'b1, "R7 done pulse", 128'(done), 128'd1);
    chk(busy == 1'b0 && resValid == 1'b0, "R7 idle at done", {busy, resValid}, 128'd0);
    chk(carryOut == carry, vl == 0 && vm ? "R9 carry passthrough" : "R5 carryOut",
        128'(carryOut), 128'(carry));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAX_VL; i++) opMem[i] = 64'hFFFF_FFFF_FFFF_FFFF - 64'(i * 3);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && resValid == 1'b0 && done == 1'b0, "R7 reset idle",
        {busy, resValid, done}, 128'd0);
    rstN = 1'b1;

    // scalar table walk (R1, R2, R3); vecLen set to show it has no effect
    for (int t = 0; t < NVEC; t++) begin
      opMem[0] = SCAL[t][191:128];
      runOp(1'b0, 5, SBASE[t], SCAL[t][127:64], SCAL[t][63:0], 1'b0);
    end
    // explicit corner values: R1 all ones, R2 zero extension
    chk(mulAdd('1, '1, '1) == {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, "R1 max model",
        mulAdd('1, '1, '1), {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
    opMem[0] = 64'd0;
    runOp(1'b0, 0, 7'd9, 64'd0, 64'h8000_0000_0000_0000, 1'b0);
    chk(resHi == 64'd0, "R2 no sign extension", 128'(resHi), 128'd0);

    for (int i = 0; i < MAX_VL; i++) opMem[i] = 64'hFFFF_FFFF_FFFF_FFFF - 64'(i * 3);
    runOp(1'b1, 4, 7'd10, 64'hFFFF_FFFF_0000_0001, 64'h1111, 1'b0);        // R4 R5
    runOp(1'b1, 8, 7'd120, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); // R4 wrap
    runOp(1'b1, 12, 7'd30, 64'd12345, 64'd7, 1'b0);                        // R10 clamp
    runOp(1'b1, 0, 7'd5, 64'd3, 64'hABCD_0000_1234, 1'b0);                 // R9
    runOp(1'b1, 5, 7'd40, 64'h0123_4567_89AB_CDEF, 64'd1, 1'b1);           // R8 inject

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule